// File: doc/BRIEF.md
# Hsync-Referenced Clamp Pulse Generator

This block decides when the three colour channels of a video capture front end are clamped, and to which level. In internal mode, a timer starts at each leading edge of horizontal sync, waits a programmable number of clocks (the placement), then holds the clamp active for a programmable number of clocks (the duration). In external mode, a clamp pin supplied from off the block drives the clamp instead. The pin passes through a two-flop synchronizer and then through a polarity correction, so that either active level can be used.

Each channel has its own target select. A channel set to ground gets target code zero. A channel set to midscale gets the half-scale code. The clamp-active level applies to all three channels at once. The source select, polarity and target selects are registered inside the block. Placement and duration are captured when the leading edge is detected, so changing them during a window does not disturb that window.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst_n` is sampled low, `clamp_o` is low and every target code is 0, whatever the inputs are. Reset leaves the block in internal mode with positive external polarity.
- R2: A leading edge is the clock edge at which `hsync_i` is sampled high after having been sampled low. Call the cycle that follows that edge cycle 0. In internal mode, `clamp_o` is high in cycle k exactly when P ≤ k < P+D. P and D are the `place_i` and `dur_i` values sampled at the detecting edge, and later changes to them have no effect on that window.
- R3: A new leading edge that arrives during a window restarts the count from that edge, using the values sampled at the new edge.
- R4: With a duration of 0, the internal clamp never asserts.
- R5: Holding `hsync_i` high for many cycles produces only one window. A falling edge of `hsync_i` starts nothing.
- R6: With `src_sel_i` = 1 (external), `clamp_o` in a cycle equals the value of `clamp_pin_i` driven two clock edges earlier. It is used as is when `clamp_pol_i` = 1 (active high) and inverted when `clamp_pol_i` = 0 (active low). Source and polarity take effect at the first edge after they are driven.
- R7: In external mode `hsync_i` has no effect on `clamp_o`. In internal mode `clamp_pin_i` has no effect on `clamp_o`.
- R8: Channel c (red 0, green 1, blue 2) occupies bits [8c+7:8c] of `tgt_code_o`. The code is 0 when `mid_sel_i[c]` = 0 (ground) and 128 when it is 1 (midscale), and it updates at the first edge after the select is driven.
- R9: At the largest settings (P = 255, D = 255) the window covers cycles 255 through 509 and then ends, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync level, active high, synchronous to clk |
| clamp_pin_i | input | 1 | External clamp request, asynchronous |
| src_sel_i | input | 1 | Clamp source: 0 internal timer, 1 external pin |
| clamp_pol_i | input | 1 | External pin active level: 1 high, 0 low |
| place_i | input | 8 | Clocks from the leading edge to the clamp start |
| dur_i | input | 8 | Clamp length in clocks; 0 disables the internal clamp |
| mid_sel_i | input | 3 | Per-channel target: 0 ground, 1 midscale (bit 0 red) |
| clamp_o | output | 1 | Clamp active, all channels |
| tgt_code_o | output | 24 | Per-channel clamp target code, 8 bits per channel |

## Verification
The hardest case to reach is a leading edge that lands inside a window that is still running. At the ports, this only shows up as a gap of low cycles followed by a fresh window. The stimulus pulses `hsync_i` low and high again partway through the first window, then compares the clamp against the position of the second edge. The bench also changes placement and duration right after a capturing edge, and toggles the external pin while internal mode is active, to show that neither reaches the output. The largest placement and duration are run to completion to exercise the widened counter.

// File: rtl/clmp_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the clamp pulse generator.
// Assumes: consumers pick widths through their own parameters.
package clmp_pkg;

    // Clamp source selection, encoded as the select input bit.
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clamp_src_e;

    // Registered operating mode.
    typedef struct packed {
        clamp_src_e src;
        logic       pol_high;
    } clamp_mode_t;

endpackage

// File: rtl/clmp_cfg_regs.sv
`timescale 1ns/1ps
// Module: clmp_cfg_regs
// Registers the mode and per-channel target selects so that they have
// defined reset values: internal source, positive polarity, all ground.
// Assumes: select inputs are synchronous to clk.
module clmp_cfg_regs
    import clmp_pkg::*;
#(
    parameter int CHAN_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel_i,
    input  logic              pol_i,
    input  logic [CHAN_N-1:0] mid_sel_i,
    output clamp_mode_t       mode_o,
    output logic [CHAN_N-1:0] mid_sel_o
);

    clamp_mode_t       mode_q;
    logic [CHAN_N-1:0] mid_q;

    // Capture the mode and selects, applying reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.src      <= SRC_INT;
            mode_q.pol_high <= 1'b1;
            mid_q           <= '0;
        end else begin
            mode_q.src      <= clamp_src_e'(src_sel_i);
            mode_q.pol_high <= pol_i;
            mid_q           <= mid_sel_i;
        end
    end

    assign mode_o    = mode_q;
    assign mid_sel_o = mid_q;

endmodule

// File: rtl/clmp_hs_timer.sv
`timescale 1ns/1ps
// Module: clmp_hs_timer
// Counts clocks from each hsync leading edge and raises win_o while the
// count lies in [placement, placement + duration). The settings are
// captured at the edge. The counter is one bit wider than the settings
// and saturates, so the largest window never wraps.
// Assumes: hsync_i is synchronous to clk.
module clmp_hs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic [CNT_W-1:0] place_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             win_o
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

    logic             hs_q;
    logic             lead;
    logic [SUM_W-1:0] cnt_q;
    logic [CNT_W-1:0] place_q;
    logic [CNT_W-1:0] dur_q;
    logic [SUM_W-1:0] start_pt;
    logic [SUM_W-1:0] end_pt;

    // Keep the previous hsync level; reset high so a level that is already high is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b1;
        else        hs_q <= hsync_i;
    end

    assign lead = hsync_i & ~hs_q;

    // Restart the count and capture the settings at a leading edge; otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '1;
            place_q <= '0;
            dur_q   <= '0;
        end else if (lead) begin
            cnt_q   <= '0;
            place_q <= place_i;
            dur_q   <= dur_i;
        end else if (cnt_q != '1) begin
            cnt_q   <= cnt_q + ONE;
        end
    end

    // Compare the count against the captured window bounds.
    always_comb begin
        start_pt = {1'b0, place_q};
        end_pt   = {1'b0, place_q} + {1'b0, dur_q};
        win_o    = (cnt_q >= start_pt) && (cnt_q < end_pt);
    end

    // R2: a detected leading edge always restarts the count.
    a_r2_lead_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> (cnt_q == '0));

    // R4: a zero duration keeps the window closed.
    a_r4_zero_dur_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (dur_q == '0) |-> !win_o);

    // R3: the window closes after its last cycle unless a new edge arrives.
    a_r3_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o && !lead && (cnt_q == end_pt - ONE)) |=> !win_o);

endmodule

// File: rtl/clmp_ext_sync.sv
`timescale 1ns/1ps
// Module: clmp_ext_sync
// A chain of flops that brings the asynchronous clamp pin into the clk domain.
// Assumes: STAGES >= 2.
module clmp_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic ext_o
);

    logic [STAGES-1:0] stg_q;
    logic              up_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], ext_i};
    end

    // Mark that the previous edge was outside reset (used by the checks).
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    assign ext_o = stg_q[STAGES-1];

    // R6: the first stage holds the pin value from the previous edge.
    a_r6_stage_first: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> (stg_q[0] == $past(ext_i)));

    for (genvar i = 1; i < STAGES; i++) begin : g_stage_chk
        // R6: each later stage holds its predecessor's value from the previous edge.
        a_r6_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
            up_q |-> (stg_q[i] == $past(stg_q[i-1])));
    end

endmodule

// File: rtl/clamp_pulse_gen.sv
`timescale 1ns/1ps
// Module: clamp_pulse_gen (top)
// Selects the clamp from the hsync timer or the synchronized, polarity-
// corrected external pin, and produces a ground or midscale target code
// for each channel.
// Assumes: hsync_i and the settings are synchronous to clk; the pin is not.
module clamp_pulse_gen
    import clmp_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int CHAN_N      = 3,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hsync_i,
    input  logic                     clamp_pin_i,
    input  logic                     src_sel_i,
    input  logic                     clamp_pol_i,
    input  logic [CNT_W-1:0]         place_i,
    input  logic [CNT_W-1:0]         dur_i,
    input  logic [CHAN_N-1:0]        mid_sel_i,
    output logic                     clamp_o,
    output logic [CHAN_N*CODE_W-1:0] tgt_code_o
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    clamp_mode_t       mode_q;
    logic [CHAN_N-1:0] mid_q;
    logic              win;
    logic              ext_s;
    logic              ext_act;
    logic              up_q;

    clmp_cfg_regs #(.CHAN_N(CHAN_N)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel_i (src_sel_i),
        .pol_i     (clamp_pol_i),
        .mid_sel_i (mid_sel_i),
        .mode_o    (mode_q),
        .mid_sel_o (mid_q)
    );

    clmp_hs_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync_i (hsync_i),
        .place_i (place_i),
        .dur_i   (dur_i),
        .win_o   (win)
    );

    clmp_ext_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ext_i (clamp_pin_i),
        .ext_o (ext_s)
    );

    // Correct the pin polarity, then pick the active clamp source.
    always_comb begin
        ext_act = mode_q.pol_high ? ext_s : ~ext_s;
        clamp_o = (mode_q.src == SRC_EXT) ? ext_act : win;
    end

    // Per-channel target code: midscale or ground.
    for (genvar c = 0; c < CHAN_N; c++) begin : g_lane
        assign tgt_code_o[c*CODE_W +: CODE_W] = mid_q[c] ? MID_CODE : '0;
    end

    // Mark that the previous edge was outside reset (used by the checks).
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    for (genvar c = 0; c < CHAN_N; c++) begin : g_lane_chk
        // R8: each lane's code follows the select driven before the last edge.
        a_r8_code_tracks_sel: assert property (@(posedge clk) disable iff (!rst_n)
            up_q |-> (tgt_code_o[c*CODE_W +: CODE_W] ==
                      ($past(mid_sel_i[c]) ? MID_CODE : {CODE_W{1'b0}})));
    end

endmodule

// File: tb/clamp_pulse_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected item per cycle, and the
// monitor pops it just after the following rising edge and compares.
module clamp_pulse_gen_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        rst_n, hsync, pin, src_sel, pol;
    logic [7:0]  place, dur;
    logic [2:0]  mid_sel;
    logic        clamp;
    logic [23:0] codes;

    clamp_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .clamp_pin_i(pin),
        .src_sel_i(src_sel), .clamp_pol_i(pol), .place_i(place), .dur_i(dur),
        .mid_sel_i(mid_sel), .clamp_o(clamp), .tgt_code_o(codes)
    );

    typedef struct {
        logic        cl;
        bit          chk_cl;
        logic [23:0] code;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Desired input values, applied by tick at the next falling edge.
    logic       d_rst = 0, d_hs = 0, d_pin = 0, d_src = 0, d_pol = 1;
    logic [2:0] d_mid = 0;
    logic [7:0] d_place = 0, d_dur = 0;
    logic       prev_pin = 0;

    function automatic logic [23:0] code_for(input logic [2:0] m);
        logic [23:0] v;
        for (int c = 0; c < 3; c++) v[c*8 +: 8] = m[c] ? 8'd128 : 8'd0;
        return v;
    endfunction

    // Drive the desired inputs and push the expectation for the next sample.
    task automatic tick(input logic ecl, input bit ccl, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = d_rst; hsync = d_hs; pin = d_pin; src_sel = d_src; pol = d_pol;
        mid_sel = d_mid; place = d_place; dur = d_dur;
        it.cl     = d_rst ? ecl : 1'b0;
        it.chk_cl = ccl;
        it.code   = d_rst ? code_for(d_mid) : 24'd0;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                if (it.chk_cl) begin
                    n_chk++;
                    if (clamp !== it.cl) begin
                        n_fail++;
                        $display("FAIL %s clamp actual=%0b expected=%0b t=%0t", it.tag, clamp, it.cl, $time);
                    end
                end
                n_chk++;
                if (codes !== it.code) begin
                    n_fail++;
                    $display("FAIL %s/R8 codes actual=%06h expected=%06h t=%0t",
                             it.tag, codes, it.code, $time);
                end
            end
        end
    end

    // Internal-mode run: a leading edge at k=0 and an optional second one at r2 > 0.
    // When there is no second edge, the settings are scrambled after capture (R2).
    task automatic hs_run(input int p, input int d, input int hold, input int r2,
                          input int total, input string tag);
        int last;
        int kk;
        d_src = 0;
        d_place = 8'(p); d_dur = 8'(d);
        for (int k = 0; k < total; k++) begin
            d_hs  = (k < hold) || (r2 > 0 && k >= r2 && k < r2 + hold);
            d_pin = k[0];   // R7: pin activity ignored in internal mode
            if (r2 == 0 && k >= 1) begin
                d_place = 8'(p + 37);
                d_dur   = 8'(d ^ 8'h5A);
            end
            last = (r2 > 0 && k >= r2) ? r2 : 0;
            kk   = k - last;
            tick((kk >= p) && (kk < p + d), 1, tag);
        end
        d_hs = 0; d_pin = 0;
        tick(0, 1, tag);
        tick(0, 1, tag);
    endtask

    // External-mode run driven by a pin pattern; hsync pulses if asked (R7).
    task automatic ext_run(input logic polv, input logic [15:0] pat, input bit hs_tgl,
                           input string tag);
        logic e;
        d_src = 1; d_pol = polv; d_place = 0; d_dur = 3;
        for (int i = 0; i < 16; i++) begin
            d_pin = pat[i];
            d_hs  = hs_tgl ? logic'(i[1]) : 1'b0;
            e = polv ? prev_pin : ~prev_pin;
            prev_pin = d_pin;
            tick(e, 1, tag);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run incomplete actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset holds the outputs low even with active inputs.
        d_rst = 0; d_mid = 3'b111; d_pin = 1; d_src = 1; d_pol = 0; d_hs = 0;
        for (int i = 0; i < 4; i++) tick(0, 1, "R1");
        d_rst = 1; d_mid = 3'b000; d_pin = 0; d_src = 0; d_pol = 1;
        for (int i = 0; i < 4; i++) tick(0, 1, "R1");

        hs_run(3, 4, 6, 0, 14, "R2");
        hs_run(0, 1, 1, 0, 5, "R2");
        hs_run(1, 0, 3, 0, 8, "R4");
        hs_run(2, 5, 20, 0, 24, "R5");
        hs_run(3, 6, 2, 5, 18, "R3");
        hs_run(255, 255, 4, 0, 514, "R9");

        // R6: external path with both polarities; R7: hsync ignored there.
        prev_pin = 0;
        ext_run(1'b1, 16'b1011_0011_1000_1101, 1'b0, "R6");
        ext_run(1'b0, 16'b0110_1100_0101_0011, 1'b0, "R6");
        ext_run(1'b1, 16'b1100_1010_0110_0101, 1'b1, "R7");
        d_pin = 0; prev_pin = 0;
        tick(1, 0, "R6"); tick(0, 1, "R6");

        // Back to internal mode with the timer idle: clamp stays low.
        d_src = 0; d_hs = 0;
        for (int i = 0; i < 3; i++) tick(0, 1, "R7");

        // R8: every select combination.
        for (int m = 0; m < 8; m++) begin
            d_mid = 3'(m);
            tick(0, 1, "R8");
        end
        d_mid = 0;
        tick(0, 1, "R8");

        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule